// File: doc/BRIEF.md
# Run-Length Tagged Instruction Prefetch Queue

This block is a byte-wide instruction prefetch queue that sits between a code memory read port and an instruction decoder. It only fetches in cycles that the execution side marks as leaving the bus free. It models each instruction as one byte. A reserved marker byte in the code stream states how many of the bytes that follow it are certain to execute in order. The queue takes in that marker and never passes it to decode. It then prefetches exactly that many bytes and no more. When the bus supports bursts, it asks for the whole known run in one burst. The burst is cut short when free queue slots are fewer than the run.

Without a guarantee, the queue fetches only one byte ahead, and only when it is empty. A guarantee is absent after reset, after a redirect, after a marker whose count is zero, and once a run has been used up. The decoder pops bytes in address order. A redirect empties the queue and the run counter in one cycle and moves fetching to a new address. Any burst beats still owed by memory are dropped.

The fetch side is a three-state machine:
- `S_READY`: no beats outstanding. A request is issued from here when the bus is idle and there is work to do (`READY -> BUSY`). A redirect keeps the machine in `S_READY`.
- `S_BUSY`: a request's beats are arriving. The last beat moves it to `S_READY`. A redirect moves it to `S_DISCARD`, or to `S_READY` if that beat was the last one.
- `S_DISCARD`: leftover beats of a redirected request are thrown away. The last beat moves it to `S_READY`.

Top module: `tagrun_prefetch`

## Requirements
- R1: `mem_req` is high only in a cycle where `bus_idle` is high; while `bus_idle` stays low no request is made.
- R2: A byte whose bits 7:5 are all ones is a run marker, and bits 4:0 hold its run count. A marker is never presented on `dec_byte`.
- R3: After a marker with count N>0, the queue requests the N bytes that follow the marker and then requests nothing more. This holds until a redirect, or until a new marker arrives through the one-ahead fetch.
- R4: Within a run, a request covers min(remaining run, free slots) beats as one burst starting at the next fetch address. It never exceeds either limit.
- R5: The queue holds 16 bytes. With the queue full, no request is made. After pops, the next request is bounded by the slots freed.
- R6: With no guarantee (after reset, after a redirect, after a count-0 marker, or after a run is used up), a single one-byte request is made, and only when the queue is empty.
- R7: A redirect (`flush` high) empties the queue and the run counter. `dec_valid` is low in the next cycle, and the next request starts at `flush_addr`.
- R8: Beats still owed to a request outstanding at a redirect are discarded and never reach decode.
- R9: Bytes reach `dec_byte` in fetch-address order. A pop while `dec_valid` is low has no effect.
- R10: After reset `dec_valid` is low and fetching starts at address 0. At most one request is outstanding at a time: `mem_req` is never high while beats are owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_idle | input | 1 | Execution side leaves the bus free this cycle |
| mem_req | output | 1 | Read request, accepted in the cycle it is high |
| mem_addr | output | AW | Start address of the request |
| mem_len | output | clog2(DEPTH+1) | Beats requested (1 for a single read) |
| mem_rvalid | input | 1 | A read beat is returned this cycle |
| mem_rdata | input | 8 | Returned byte |
| dec_pop | input | 1 | Decoder takes the head byte |
| dec_valid | output | 1 | Head byte is valid |
| dec_byte | output | 8 | Head byte |
| flush | input | 1 | Redirect: empty the queue and restart fetching |
| flush_addr | input | AW | New fetch address on redirect |

## Verification
The hardest case to reach from the ports is a redirect that lands while a multi-beat burst is only partly returned. The bench places a marker so that a long burst is issued. It waits until that request shows up on the memory port, lets two beats arrive, and then redirects. It then checks three things: the stale beats never reach decode, exactly one single-byte request is made at the new address, and the first decoded byte comes from that address. The free-slot bound is reached by filling the queue from a long run, blocking the bus, popping a few bytes, and then releasing the bus.

// File: rtl/tagrun_pkg.sv
package tagrun_pkg;

    localparam int CNT_W = 5;
    localparam logic [2:0] MARK_BITS = 3'b111;

    typedef enum logic [1:0] {
        S_READY   = 2'd0,
        S_BUSY    = 2'd1,
        S_DISCARD = 2'd2
    } fetch_state_t;

    function automatic logic is_marker(input logic [7:0] b);
        return b[7:5] == MARK_BITS;
    endfunction

endpackage

// File: rtl/tagrun_fifo.sv
module tagrun_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [W-1:0]     wdata,
    input  logic             rd,
    output logic [W-1:0]     rdata,
    output logic [LEN_W-1:0] count,
    output logic [LEN_W-1:0] free
);
    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wp, rp;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr && !clr) slots[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr) wp <= bump(wp);
            if (rd) rp <= bump(rp);
            unique case ({wr, rd})
                2'b10:   count <= count + LEN_W'(1);
                2'b01:   count <= count - LEN_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign rdata = slots[rp];
    assign free  = LEN_W'(DEPTH) - count;
endmodule

// File: rtl/tagrun_run_ctr.sv
module tagrun_run_ctr
    import tagrun_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             beat,
    input  logic [7:0]       beat_byte,
    output logic             store,
    output logic [CNT_W-1:0] run_left
);
    logic marker;

    assign marker = is_marker(beat_byte);
    assign store  = beat && !marker;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_left <= '0;
        end else if (clr) begin
            run_left <= '0;
        end else if (beat) begin
            if (marker)
                run_left <= beat_byte[CNT_W-1:0];
            else if (run_left != '0)
                run_left <= run_left - CNT_W'(1);
        end
    end
endmodule

// File: rtl/tagrun_fetch_fsm.sv
module tagrun_fetch_fsm
    import tagrun_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          DEPTH      = 16,
    parameter bit          BURST_EN   = 1'b1,
    parameter logic [AW-1:0] RESET_ADDR = '0,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_idle,
    input  logic             flush,
    input  logic [AW-1:0]    flush_addr,
    input  logic             rvalid,
    input  logic [CNT_W-1:0] run_left,
    input  logic [LEN_W-1:0] q_count,
    input  logic [LEN_W-1:0] q_free,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic [LEN_W-1:0] mem_len,
    output logic             beat_ok,
    output logic [LEN_W-1:0] owed
);
    fetch_state_t state, nxt;
    logic [7:0]   run_e, free_e, run_lim, want;
    logic         issue, last_beat;
    logic [AW-1:0] fetch_addr;

    assign run_e  = 8'(run_left);
    assign free_e = 8'(q_free);

    generate
        if (BURST_EN) begin : g_burst
            assign run_lim = (run_e < free_e) ? run_e : free_e;
        end else begin : g_single
            assign run_lim = (free_e != 8'd0) ? 8'd1 : 8'd0;
        end
    endgenerate

    always_comb begin
        if (run_left == '0)
            want = (q_count == '0) ? 8'd1 : 8'd0;
        else
            want = run_lim;
    end

    assign last_beat = rvalid && (owed == LEN_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_READY;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_READY: begin
                if (!flush && issue) nxt = S_BUSY;
            end
            S_BUSY: begin
                if (flush)          nxt = last_beat ? S_READY : S_DISCARD;
                else if (last_beat) nxt = S_READY;
            end
            S_DISCARD: begin
                if (last_beat) nxt = S_READY;
            end
            default: nxt = S_READY;
        endcase
    end

    // outputs
    always_comb begin
        issue   = 1'b0;
        beat_ok = 1'b0;
        unique case (state)
            S_READY:   issue   = !flush && bus_idle && (want != 8'd0);
            S_BUSY:    beat_ok = rvalid && !flush;
            S_DISCARD: beat_ok = 1'b0;
            default:   issue   = 1'b0;
        endcase
        mem_req  = issue;
        mem_addr = fetch_addr;
        mem_len  = issue ? want[LEN_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_addr <= RESET_ADDR;
            owed       <= '0;
        end else begin
            if (flush)      fetch_addr <= flush_addr;
            else if (issue) fetch_addr <= fetch_addr + AW'(want);
            if (issue)                       owed <= want[LEN_W-1:0];
            else if (rvalid && owed != '0)   owed <= owed - LEN_W'(1);
        end
    end
endmodule

// File: rtl/tagrun_prefetch.sv
module tagrun_prefetch
    import tagrun_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int AW       = 16,
    parameter bit BURST_EN = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_idle,
    output logic                       mem_req,
    output logic [AW-1:0]              mem_addr,
    output logic [$clog2(DEPTH+1)-1:0] mem_len,
    input  logic                       mem_rvalid,
    input  logic [7:0]                 mem_rdata,
    input  logic                       dec_pop,
    output logic                       dec_valid,
    output logic [7:0]                 dec_byte,
    input  logic                       flush,
    input  logic [AW-1:0]              flush_addr
);
    localparam int LEN_W = $clog2(DEPTH + 1);

    logic             beat_ok, q_wr, q_rd;
    logic [CNT_W-1:0] run_left;
    logic [LEN_W-1:0] q_count, q_free, owed;

    assign dec_valid = (q_count != '0);
    assign q_rd      = dec_pop && dec_valid && !flush;

    tagrun_fetch_fsm #(
        .AW(AW), .DEPTH(DEPTH), .BURST_EN(BURST_EN), .RESET_ADDR('0)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle),
        .flush(flush), .flush_addr(flush_addr), .rvalid(mem_rvalid),
        .run_left(run_left), .q_count(q_count), .q_free(q_free),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
        .beat_ok(beat_ok), .owed(owed)
    );

    tagrun_run_ctr u_run (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .beat(beat_ok), .beat_byte(mem_rdata),
        .store(q_wr), .run_left(run_left)
    );

    tagrun_fifo #(.DEPTH(DEPTH), .W(8)) u_q (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .wr(q_wr), .wdata(mem_rdata), .rd(q_rd), .rdata(dec_byte),
        .count(q_count), .free(q_free)
    );
endmodule

// File: rtl/tagrun_checker.sv
module tagrun_checker #(
    parameter int DEPTH = 16,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_idle,
    input logic             mem_req,
    input logic [LEN_W-1:0] mem_len,
    input logic             mem_rvalid,
    input logic             flush,
    input logic             dec_valid,
    input logic [7:0]       dec_byte,
    input logic [4:0]       run_left,
    input logic [LEN_W-1:0] q_count,
    input logic [LEN_W-1:0] q_free,
    input logic             q_wr,
    input logic [LEN_W-1:0] owed
);
    AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> bus_idle); // R1
    AST_NO_MARKER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> dec_byte[7:5] != 3'b111); // R2
    AST_LEN_WITHIN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && run_left != 5'd0) |-> (LEN_W+1)'(mem_len) <= (LEN_W+1)'(run_left) && mem_len <= q_free); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q_wr |-> q_count < LEN_W'(DEPTH)); // R5
    AST_FALLBACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && run_left == 5'd0) |-> (mem_len == LEN_W'(1) && q_count == '0)); // R6
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !dec_valid); // R7
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> owed == '0); // R10
    AST_BEAT_OWED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> owed != '0); // R10
endmodule

bind tagrun_prefetch tagrun_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .mem_req(mem_req),
    .mem_len(mem_len), .mem_rvalid(mem_rvalid), .flush(flush),
    .dec_valid(dec_valid), .dec_byte(dec_byte), .run_left(run_left),
    .q_count(q_count), .q_free(q_free), .q_wr(q_wr), .owed(owed)
);

// File: tb/tb_tagrun_prefetch.sv
`timescale 1ns/1ps
module tb_tagrun_prefetch;
    localparam int DEPTH = 16;
    localparam int AW    = 16;
    localparam int LEN_W = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0, bus_idle = 1'b0;
    logic mem_req, mem_rvalid = 1'b0, dec_pop = 1'b0, dec_valid, flush = 1'b0;
    logic [AW-1:0] mem_addr, flush_addr = '0;
    logic [LEN_W-1:0] mem_len;
    logic [7:0] mem_rdata = 8'h00, dec_byte;

    always #10 clk = ~clk;

    tagrun_prefetch #(.DEPTH(DEPTH), .AW(AW), .BURST_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .dec_pop(dec_pop), .dec_valid(dec_valid), .dec_byte(dec_byte),
        .flush(flush), .flush_addr(flush_addr)
    );

    logic [7:0] mem [256];
    int req_a [64];
    int req_l [64];
    int req_n = 0;
    int resp_addr = 0, resp_left = 0;
    int checks = 0, fails = 0;
    bit done = 0;

    // memory responder and request log
    always @(posedge clk) begin
        if (resp_left > 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[resp_addr[7:0]];
            resp_addr  <= resp_addr + 1;
            resp_left  <= resp_left - 1;
        end else begin
            mem_rvalid <= 1'b0;
        end
        if (mem_req) begin
            resp_addr <= int'(mem_addr);
            resp_left <= int'(mem_len);
            if (req_n < 64) begin
                req_a[req_n] <= int'(mem_addr);
                req_l[req_n] <= int'(mem_len);
            end
            req_n <= req_n + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'(i & 127);
    endtask

    task automatic redirect(input int addr, output int base);
        flush_addr = AW'(addr);
        flush = 1'b1;
        tick(1);
        flush = 1'b0;
        base = req_n;
    endtask

    task automatic pop_check(input string req, input int exp);
        check({req, " valid"}, int'(dec_valid), 1);
        check({req, " byte"}, int'(dec_byte), exp);
        dec_pop = 1'b1;
        tick(1);
        dec_pop = 1'b0;
    endtask

    task automatic t_reset();
        fill_mem();
        rst_n = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(10);
        check("R10 reset dec_valid", int'(dec_valid), 0);
        check("R1 no request while bus busy", req_n, 0);
        bus_idle = 1'b1;
        tick(20);
        check("R10 first request count", req_n, 1);
        check("R10 first request addr", req_a[0], 0);
        check("R6 first request single", req_l[0], 1);
        pop_check("R9 first byte", 0);
        tick(10);
        check("R6 next one-ahead addr", req_a[1], 1);
        check("R6 one-ahead request count", req_n, 2);
    endtask

    task automatic t_run_and_new_marker();
        int b;
        mem[8'h10] = 8'hE5;
        mem[8'h16] = 8'hE2;
        redirect(16'h10, b);
        tick(30);
        check("R3 requests for run", req_n - b, 2);
        check("R6 marker fetched alone", req_l[b], 1);
        check("R4 burst addr", req_a[b + 1], 16'h11);
        check("R4 burst len", req_l[b + 1], 5);
        for (int i = 0; i < 5; i++) pop_check("R2 run bytes skip marker", 16'h11 + i);
        tick(30);
        check("R3 new marker fetch addr", req_a[b + 2], 16'h16);
        check("R3 new run addr", req_a[b + 3], 16'h17);
        check("R3 new run len", req_l[b + 3], 2);
        pop_check("R3 new run byte0", 8'h17);
        pop_check("R3 new run byte1", 8'h18);
    endtask

    task automatic t_free_bound();
        int b;
        mem[8'h40] = 8'hFF;
        redirect(16'h40, b);
        tick(40);
        check("R5 requests until full", req_n - b, 2);
        check("R4 burst capped by space", req_l[b + 1], 16);
        bus_idle = 1'b0;
        for (int i = 0; i < 3; i++) pop_check("R9 ordered pop", 16'h41 + i);
        tick(5);
        check("R5 no request while bus busy", req_n - b, 2);
        bus_idle = 1'b1;
        tick(20);
        check("R5 refill addr", req_a[b + 2], 16'h51);
        check("R5 refill len bounded by freed", req_l[b + 2], 3);
        check("R5 refill only once", req_n - b, 3);
    endtask

    task automatic t_flush_mid_burst();
        int b, fb;
        mem[8'h80] = 8'hE8;
        redirect(16'h80, b);
        for (int i = 0; i < 20; i++) if (req_n - b < 2) tick(1);
        check("R4 long burst issued", req_l[b + 1], 8);
        tick(2);
        redirect(16'hC0, fb);
        check("R7 dec_valid low after flush", int'(dec_valid), 0);
        tick(30);
        check("R8 single request after flush", req_n - fb, 1);
        check("R7 request at new address", req_a[fb], 16'hC0);
        pop_check("R8 stale beats dropped", 8'h40);
    endtask

    task automatic t_zero_count();
        int b;
        mem[8'h30] = 8'hE0;
        redirect(16'h30, b);
        tick(30);
        check("R6 zero count requests", req_n - b, 2);
        check("R6 zero count second addr", req_a[b + 1], 16'h31);
        check("R6 zero count second len", req_l[b + 1], 1);
        pop_check("R6 zero count byte", 8'h31);
    endtask

    task automatic t_pop_empty();
        int b;
        bus_idle = 1'b0;
        redirect(16'h20, b);
        for (int i = 0; i < 3; i++) begin
            dec_pop = 1'b1;
            tick(1);
            check("R9 pop on empty keeps invalid", int'(dec_valid), 0);
        end
        dec_pop = 1'b0;
        check("R1 no request with bus busy", req_n - b, 0);
        bus_idle = 1'b1;
        tick(10);
        pop_check("R9 byte after ignored pops", 8'h20);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_run_and_new_marker();
        t_free_bound();
        t_flush_mid_burst();
        t_zero_count();
        t_pop_empty();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule